// File: doc/BRIEF.md
# Third-Order Fractional Division Modulator

This block turns a fixed-point fractional word into a stream of small signed integers that a fractional-N frequency synthesizer adds to its integer division ratio, one value per reference period. The long-run mean of the stream equals the fractional word divided by 2^16. The quantization error is pushed to high offset frequencies by a third-order noise transfer function, (1 − z⁻¹)³. This leaves the residual error for the loop filter to remove.

The modulator is a single error-feedback loop. The three most recent quantizer residues are weighted by +3, −3 and +1 and added to the input word. A multi-level quantizer then splits the sum into an integer offset and a new residue. An optional pseudo-random bit from a 23-bit maximal-length shift register can be added at the least significant position to break up idle tones for rational fractions. The block is clocked at the reference rate and updates on every clock edge.

Top module: `sdm3_frac_mod`

## Requirements
- R1: While `rst_n` is low, `ofs_o` is 0 and `vld_o` is 0, and all residue and offset state is cleared.
- R2: `vld_o` rises on the first rising clock edge after `rst_n` goes high and stays high until the next reset.
- R3: `ofs_o` is a 4-bit two's complement value that always lies in the range −3 to +4.
- R4: On each edge the block forms u = M + d + 3·e1 − 3·e2 + e3, where M is `frac_i`, d is the dither bit, and e1, e2, e3 are the residues of the previous three edges (zero after reset). It registers y = floor(u / 2^16) into `ofs_o` and keeps e = u − y·2^16 as the new residue.
- R5: With dither off, over the first N outputs after reset the sum of the outputs differs from N·M/2^16 by less than 2.
- R6: With `frac_i` = 0 and dither off, `ofs_o` stays 0 on every cycle.
- R7: The dither bit d is `dith_en_i` AND bit 0 of a 23-bit shift register. The register resets to 1 and on every edge becomes {s[21:0], s[22] XOR s[17]}. With `dith_en_i` low, d is 0.
- R8: The internal sum never exceeds its 20-bit signed range for any M from 0 to 65535, with dither on or off.
- R9: A change of `dith_en_i` affects the output registered on the same edge at which it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| frac_i | input | 16 | Fractional word M, unsigned, in units of 2^-16 |
| dith_en_i | input | 1 | Enables the pseudo-random LSB dither |
| ofs_o | output | 4 | Signed division-ratio offset for the current reference period |
| vld_o | output | 1 | High while `ofs_o` carries a modulator output |

## Verification
The dither bit and a residue carry can land in the same cycle. With M = 65535 and dither on, the injected bit alone pushes the quantizer sum past 2^16, and the feedback terms can push it to its extreme at the same time. The bench sweeps the largest fractional words with dither enabled and with dither toggled every few cycles, so these coincidences occur many times. Each output is compared with an arithmetic evaluation of the R4 recurrence, driven by the R7 register sequence, and is also checked against the −3 to +4 range.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

  // Noise-shaping order of the error-feedback loop.
  localparam int unsigned SHAPE_ORDER = 3;

  // Binomial coefficient C(n, k).
  function automatic int binom(input int n, input int k);
    int r;
    r = 1;
    for (int i = 1; i <= k; i++) begin
      r = (r * (n - k + i)) / i;
    end
    return r;
  endfunction

  // Weight of the residue delayed by j cycles (j >= 1) in the feedback sum,
  // taken from the expansion of (1 - z^-1)^ORDER with the sign flipped.
  function automatic int tap_weight(input int order, input int j);
    int b;
    b = binom(order, j);
    return ((j % 2) == 1) ? b : -b;
  endfunction

endpackage

// File: rtl/sdm_lfsr.sv
module sdm_lfsr #(
  parameter int unsigned W   = 23,
  parameter int unsigned TAP = 18
) (
  input  logic clk,
  input  logic rst_n,
  output logic bit_o
);

  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = {q_r[W-2:0], q_r[W-1] ^ q_r[TAP-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= {{(W-1){1'b0}}, 1'b1};
    else        q_r <= q_nxt;
  end

  assign bit_o = q_r[0];

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    q_r != '0);  // R7

endmodule

// File: rtl/sdm_res_line.sv
module sdm_res_line #(
  parameter int unsigned RES_W = 16,
  parameter int unsigned DEPTH = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [RES_W-1:0]             res_i,
  output logic [DEPTH-1:0][RES_W-1:0]  taps_o
);

  logic [DEPTH-1:0][RES_W-1:0] h_r;
  logic [DEPTH-1:0][RES_W-1:0] h_nxt;

  always_comb begin
    h_nxt[0] = res_i;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_shift
    always_comb begin
      h_nxt[g] = h_r[g-1];
    end

    AST_RES_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> h_r[g] == $past(h_r[g-1]));  // R4
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) h_r <= '0;
    else        h_r <= h_nxt;
  end

  assign taps_o = h_r;

endmodule

// File: rtl/sdm_quant.sv
module sdm_quant
  import sdm_pkg::*;
#(
  parameter int unsigned FRAC_W = 16,
  parameter int unsigned OUT_W  = 4,
  parameter int unsigned ORDER  = 3,
  parameter int unsigned WIDE_W = 22
) (
  input  logic [FRAC_W-1:0]              frac_i,
  input  logic                           dith_i,
  input  logic [ORDER-1:0][FRAC_W-1:0]   taps_i,
  output logic signed [WIDE_W-1:0]       sum_o,
  output logic signed [OUT_W-1:0]        ofs_o,
  output logic [FRAC_W-1:0]              res_o
);

  logic signed [WIDE_W-1:0] terms [ORDER+1];

  always_comb begin
    terms[0] = $signed({{(WIDE_W-FRAC_W){1'b0}}, frac_i})
             + $signed({{(WIDE_W-1){1'b0}}, dith_i});
  end

  for (genvar j = 1; j <= ORDER; j++) begin : g_tap
    localparam int WT = tap_weight(ORDER, j);
    logic signed [WIDE_W-1:0] wt_c;
    logic signed [WIDE_W-1:0] tap_s;
    always_comb begin
      wt_c     = WIDE_W'(WT);
      tap_s    = $signed({{(WIDE_W-FRAC_W){1'b0}}, taps_i[j-1]});
      terms[j] = terms[j-1] + wt_c * tap_s;
    end
  end

  always_comb begin
    sum_o = terms[ORDER];
    ofs_o = sum_o[FRAC_W+OUT_W-1:FRAC_W];
    res_o = sum_o[FRAC_W-1:0];
  end

endmodule

// File: rtl/sdm3_frac_mod.sv
module sdm3_frac_mod
  import sdm_pkg::*;
#(
  parameter int unsigned FRAC_W   = 16,
  parameter int unsigned LFSR_W   = 23,
  parameter int unsigned LFSR_TAP = 18,
  parameter int unsigned OUT_W    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [FRAC_W-1:0]        frac_i,
  input  logic                     dith_en_i,
  output logic signed [OUT_W-1:0]  ofs_o,
  output logic                     vld_o
);

  localparam int unsigned ORDER  = SHAPE_ORDER;
  localparam int unsigned ACC_W  = FRAC_W + 4;
  localparam int unsigned WIDE_W = ACC_W + 2;
  localparam int          Y_MIN  = -(2 ** (ORDER - 1)) + 1;
  localparam int          Y_MAX  = 2 ** (ORDER - 1);

  logic                            lfsr_bit;
  logic                            dith_bit;
  logic [ORDER-1:0][FRAC_W-1:0]    taps;
  logic signed [WIDE_W-1:0]        sum_w;
  logic signed [OUT_W-1:0]         ofs_c;
  logic [FRAC_W-1:0]               res_c;

  logic signed [OUT_W-1:0]         ofs_r, ofs_nxt;
  logic                            vld_r, vld_nxt;

  sdm_lfsr #(.W(LFSR_W), .TAP(LFSR_TAP)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .bit_o (lfsr_bit)
  );

  assign dith_bit = dith_en_i & lfsr_bit;

  sdm_res_line #(.RES_W(FRAC_W), .DEPTH(ORDER)) u_hist (
    .clk    (clk),
    .rst_n  (rst_n),
    .res_i  (res_c),
    .taps_o (taps)
  );

  sdm_quant #(
    .FRAC_W (FRAC_W),
    .OUT_W  (OUT_W),
    .ORDER  (ORDER),
    .WIDE_W (WIDE_W)
  ) u_quant (
    .frac_i (frac_i),
    .dith_i (dith_bit),
    .taps_i (taps),
    .sum_o  (sum_w),
    .ofs_o  (ofs_c),
    .res_o  (res_c)
  );

  always_comb begin
    ofs_nxt = ofs_c;
    vld_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_r <= '0;
      vld_r <= 1'b0;
    end else begin
      ofs_r <= ofs_nxt;
      vld_r <= vld_nxt;
    end
  end

  assign ofs_o = ofs_r;
  assign vld_o = vld_r;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_w >= -(2 ** (ACC_W - 1))) && (sum_w < (2 ** (ACC_W - 1))));  // R8

  AST_OUT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    vld_r |-> (($signed(ofs_r) >= Y_MIN) && ($signed(ofs_r) <= Y_MAX)));  // R3

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> vld_r);  // R2

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_i == '0 && !dith_en_i && taps == '0) |=> (ofs_r == '0));  // R6

  AST_DITH_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !dith_en_i |-> !dith_bit);  // R7

endmodule

// File: tb/tb_sdm3_frac_mod.sv
`timescale 1ns/1ps
module tb_sdm3_frac_mod;

  logic              clk;
  logic              rst_n;
  logic [15:0]       frac_i;
  logic              dith_en_i;
  logic signed [3:0] ofs_o;
  logic              vld_o;

  int n_chk;
  int n_fail;
  bit done;

  // model state
  longint e1, e2, e3;
  logic [22:0] s;

  sdm3_frac_mod dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .frac_i    (frac_i),
    .dith_en_i (dith_en_i),
    .ofs_o     (ofs_o),
    .vld_o     (vld_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(ofs_o == 4'sd0, "R1 ofs in reset", ofs_o, 0);
    chk(vld_o == 1'b0, "R1 vld in reset", vld_o, 0);
    e1 = 0; e2 = 0; e3 = 0;
    s = 23'd1;
  endtask

  // mode: 0 dither off, 1 on, 2 toggling pattern
  task automatic run(input logic [15:0] m, input int mode, input int ncyc);
    longint sum_y;
    bit rng_ok;
    bit mdl_ok;
    bit zero_ok;
    sum_y = 0;
    rng_ok = 1; mdl_ok = 1; zero_ok = 1;
    do_reset();
    frac_i = m;
    dith_en_i = (mode == 1);
    rst_n = 1'b1;
    for (int n = 0; n < ncyc; n++) begin
      longint u, y, e, d;
      if (mode == 2) dith_en_i = ((n % 3) != 1);
      d = (dith_en_i && s[0]) ? 1 : 0;
      u = longint'(m) + d + 3 * e1 - 3 * e2 + e3;
      y = u >>> 16;
      e = u - (y <<< 16);
      @(posedge clk);
      @(negedge clk);
      if (n == 0) chk(vld_o == 1'b1, "R2 first valid", vld_o, 1);
      else if (vld_o !== 1'b1) chk(1'b0, "R2 valid held", vld_o, 1);
      if (longint'(ofs_o) != y) begin
        if (mdl_ok) chk(1'b0, (mode == 2) ? "R9 recurrence" : "R4 recurrence", ofs_o, y);
        mdl_ok = 0;
      end
      if (ofs_o < -4'sd3 || ofs_o > 4'sd4) begin
        if (rng_ok) chk(1'b0, "R3 range", ofs_o, 4);
        rng_ok = 0;
      end
      if (m == 0 && mode == 0 && ofs_o != 0) begin
        if (zero_ok) chk(1'b0, "R6 idle zero", ofs_o, 0);
        zero_ok = 0;
      end
      sum_y += longint'(ofs_o);
      e3 = e2; e2 = e1; e1 = e;
      s = {s[21:0], s[22] ^ s[17]};
    end
    chk(mdl_ok, (mode == 2) ? "R9 recurrence" : (mode == 1 ? "R7 R8 recurrence" : "R4 recurrence"), mdl_ok, 1);
    chk(rng_ok, "R3 range", rng_ok, 1);
    if (m == 0 && mode == 0) chk(zero_ok, "R6 idle zero", zero_ok, 1);
    if (mode == 0) begin
      longint diff;
      diff = sum_y * 65536 - longint'(ncyc) * longint'(m);
      chk(diff < 2 * 65536 && diff > -2 * 65536, "R5 mean", sum_y, (longint'(ncyc) * longint'(m)) / 65536);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    frac_i = '0;
    dith_en_i = 1'b0;
    n_chk = 0;
    n_fail = 0;
    done = 0;
    repeat (2) @(negedge clk);
    chk(ofs_o == 4'sd0 && vld_o == 1'b0, "R1 power-up reset", {ofs_o, vld_o}, 0);
    // corner words
    run(16'h0000, 0, 200);
    run(16'h0000, 1, 300);
    run(16'h0001, 0, 400);
    run(16'h8000, 0, 300);
    run(16'hFFFF, 0, 400);
    run(16'hFFFF, 1, 600);
    run(16'hFFFF, 2, 600);
    run(16'hFFFE, 1, 400);
    run(16'h5555, 2, 300);
    // sweep across the word
    for (int i = 0; i < 48; i++) begin
      logic [15:0] mw;
      mw = 16'((i * 1367 + 11) % 65536);
      run(mw, i % 3, 250);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule